// File: doc/BRIEF.md
# Noise-Synchronised Scan Gate

This block decides the moment at which a full key-matrix acquisition pass may begin, so that passes stay phase-locked to an external low-frequency interference reference such as a mains-derived logic signal. The reference arrives as a buffered digital input. It is resynchronised, and only its high-to-low transitions count as events. When the mode is enabled and a matrix pass finishes, the gate holds back the next pass. It releases the pass on the next falling reference edge, or once a bounded wait measured in millisecond ticks has run out. A run-out still starts the pass, so the scanner keeps working at a slower rate, and it also latches a failure flag that stays set until the host clears it.

The gate is consulted once per complete matrix pass, in front of the first key's burst. The scanner then runs the remaining keys back to back and reports the end of the pass with a done strobe. While the device is asleep the gate issues no start. A falling reference edge during sleep produces a one-clock wake request instead.

Top module: `noise_sync_gate`

## Requirements
- R1: During reset `scan_start`, `wake` and `sync_err` are 0. On the first clock after reset is released with `sleep` low, `scan_start` pulses for one cycle.
- R2: With `sync_en` = 0, a `scan_done` strobe sampled on a clock edge makes `scan_start` high for one cycle after that same edge.
- R3: With `sync_en` = 1, no `scan_start` follows `scan_done` until a falling edge of `sync_in`. That edge appears on `scan_start` two clocks after the first edge that samples `sync_in` low (the input passes through two synchroniser stages).
- R4: A rising edge of `sync_in`, or `sync_in` held at a constant level, never releases a waiting pass.
- R5: When no falling edge arrives, the 100th `ms_tick` counted during the wait (parameter `WAIT_TICKS`) starts the pass on the next cycle and sets `sync_err` in that same cycle.
- R6: If a falling edge and the final timeout tick fall in the same cycle, the edge wins: the pass starts and `sync_err` is not set.
- R7: Falling edges of `sync_in` while a pass is running (between `scan_start` and `scan_done`) start nothing. There is exactly one `scan_start` per `scan_done`.
- R8: `sync_err` stays set until `err_clr` is sampled high. A timeout in the same cycle as `err_clr` leaves it set.
- R9: While `sleep` is high no `scan_start` is issued. A falling `sync_in` edge during sleep pulses `wake` for exactly one cycle, with the same latency as in R3. The same edge while awake leaves `wake` at 0.
- R10: The wait counter does not advance while `sleep` is high, so no timeout or error can occur during sleep.
- R11: Clearing `sync_en` while a pass is being held back releases the pass on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| sync_in | input | 1 | Buffered interference reference, asynchronous |
| sync_en | input | 1 | 1 = align passes to the reference, 0 = free-running |
| scan_done | input | 1 | Strobe from the scanner at the end of a full matrix pass |
| sleep | input | 1 | Device is in its low-power state |
| err_clr | input | 1 | Host strobe that clears the failure flag |
| scan_start | output | 1 | One-cycle strobe that lets a full matrix pass begin |
| wake | output | 1 | One-cycle wake request on a reference edge during sleep |
| sync_err | output | 1 | Sticky flag: a wait ran out without a reference edge |

## Verification
The hardest case to reach is a falling reference edge that lands in exactly the cycle in which the wait counter would expire. The bench counts clocks from the done strobe and lowers `sync_in` three edges before the expiry edge, which allows for the two synchroniser stages and the edge register. A second hard case is a held-back pass that is put to sleep partway through its wait and later resumes. There the bench keeps ticks running through a long sleep and checks that neither a start nor an error appears until sleep drops.

// File: rtl/ns_pkg.sv
package ns_pkg;

    typedef enum logic [1:0] {
        ST_ARM  = 2'd0,
        ST_SCAN = 2'd1,
        ST_WAIT = 2'd2
    } gate_st_t;

    typedef struct packed {
        gate_st_t st;
        logic     start;
        logic     wake;
        logic     err;
    } gate_reg_t;

endpackage

// File: rtl/ns_edge.sv
module ns_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic fall_o
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[LEN-2:0], raw_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    // newest synchronised sample low, the one before it high
    assign fall_o = pipe_q[LEN-1] & ~pipe_q[LEN-2];

endmodule

// File: rtl/ns_timer.sv
module ns_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                     cnt_d = '0;
        else if (inc_i && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LAST);

endmodule

// File: rtl/noise_sync_gate.sv
module noise_sync_gate
    import ns_pkg::*;
#(
    parameter int WAIT_TICKS  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic sync_in,
    input  logic sync_en,
    input  logic scan_done,
    input  logic sleep,
    input  logic err_clr,
    output logic scan_start,
    output logic wake,
    output logic sync_err
);
    gate_reg_t fsm_d, fsm_q;
    logic      fall;
    logic      tmr_last;
    logic      tmr_inc;
    logic      tmr_clr;
    logic      err_set;

    ns_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (sync_in),
        .fall_o(fall)
    );

    ns_timer #(.LIMIT(WAIT_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .inc_i (tmr_inc),
        .last_o(tmr_last)
    );

    assign tmr_clr = (fsm_q.st != ST_WAIT);

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.start = 1'b0;
        fsm_d.wake  = sleep & fall;
        tmr_inc     = 1'b0;
        err_set     = 1'b0;

        unique case (fsm_q.st)
            ST_ARM: begin
                if (!sleep) begin
                    fsm_d.start = 1'b1;
                    fsm_d.st    = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (scan_done) begin
                    if (sync_en)     fsm_d.st    = ST_WAIT;
                    else if (sleep)  fsm_d.st    = ST_ARM;
                    else             fsm_d.start = 1'b1;
                end
            end
            ST_WAIT: begin
                if (!sleep) begin
                    if (!sync_en || fall) begin
                        fsm_d.start = 1'b1;
                        fsm_d.st    = ST_SCAN;
                    end else if (ms_tick) begin
                        tmr_inc = 1'b1;
                        if (tmr_last) begin
                            fsm_d.start = 1'b1;
                            fsm_d.st    = ST_SCAN;
                            err_set     = 1'b1;
                        end
                    end
                end
            end
            default: fsm_d.st = ST_ARM;
        endcase

        if (err_set)      fsm_d.err = 1'b1;
        else if (err_clr) fsm_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st    <= ST_ARM;
            fsm_q.start <= 1'b0;
            fsm_q.wake  <= 1'b0;
            fsm_q.err   <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign scan_start = fsm_q.start;
    assign wake       = fsm_q.wake;
    assign sync_err   = fsm_q.err;

endmodule

module noise_sync_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep,
    input logic err_clr,
    input logic scan_start,
    input logic wake,
    input logic sync_err
);
    p_no_start_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |-> !$past(sleep));

    p_wake_only_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(sleep));

    p_wake_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_err) && !$past(err_clr)) |-> sync_err);

    p_err_with_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> scan_start);

endmodule

bind noise_sync_gate noise_sync_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .err_clr   (err_clr),
    .scan_start(scan_start),
    .wake      (wake),
    .sync_err  (sync_err)
);

// File: tb/noise_sync_gate_tb.sv
module noise_sync_gate_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, sync_in = 1'b0, sync_en = 1'b0;
    logic scan_done = 1'b0, sleep = 1'b0, err_clr = 1'b0;
    logic scan_start, wake, sync_err;

    int checks = 0;
    int fails = 0;
    bit started = 0;

    always #5 clk = ~clk;

    noise_sync_gate u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sync_in(sync_in),
        .sync_en(sync_en), .scan_done(scan_done), .sleep(sleep),
        .err_clr(err_clr), .scan_start(scan_start), .wake(wake),
        .sync_err(sync_err)
    );

    // behavioural reference: phase 0 idle-ready, 1 pass running, 2 held back
    int m_phase = 0;
    int m_ticks = 0;
    bit m_start = 0, m_wake = 0, m_err = 0;
    bit h1 = 0, h2 = 0, h3 = 0;

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_phase = 0; m_ticks = 0; m_start = 0; m_wake = 0; m_err = 0;
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            bit f;
            bit seterr;
            f = (h2 == 1'b0) && (h3 == 1'b1);
            seterr = 0;
            m_start = 0;
            m_wake = sleep && f;
            if (m_phase == 0) begin
                if (!sleep) begin m_start = 1; m_phase = 1; end
            end else if (m_phase == 1) begin
                if (scan_done) begin
                    if (sync_en) begin m_phase = 2; m_ticks = 0; end
                    else if (sleep) m_phase = 0;
                    else m_start = 1;
                end
            end else begin
                if (!sleep) begin
                    if (!sync_en || f) begin m_start = 1; m_phase = 1; end
                    else if (ms_tick) begin
                        m_ticks++;
                        if (m_ticks == 100) begin
                            m_start = 1; m_phase = 1; seterr = 1;
                        end
                    end
                end
            end
            if (seterr) m_err = 1;
            else if (err_clr) m_err = 0;
            h3 = h2; h2 = h1; h1 = sync_in;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk(scan_start === m_start, "R2 R3 R5 R7 R11 scan_start vs model", scan_start, m_start);
            chk(wake === m_wake, "R9 wake vs model", wake, m_wake);
            chk(sync_err === m_err, "R5 R8 sync_err vs model", sync_err, m_err);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk); scan_done = 1'b1;
        @(negedge clk); scan_done = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(3);
        chk(scan_start == 0 && wake == 0 && sync_err == 0, "R1 reset outputs", scan_start, 0);
        rst_n = 1'b1;
        step(1);
        chk(scan_start == 1, "R1 first start", scan_start, 1);
        step(2);

        // R2 free running
        pulse_done();
        chk(scan_start == 1, "R2 start after done", scan_start, 1);
        step(2);
        pulse_done();
        chk(scan_start == 1, "R2 second start", scan_start, 1);

        // R3 / R4 gating on falling edge
        sync_en = 1'b1;
        step(2);
        pulse_done();
        step(4);
        chk(scan_start == 0, "R3 held after done", scan_start, 0);
        sync_in = 1'b1;
        step(6);
        chk(scan_start == 0, "R4 rising edge ignored", scan_start, 0);
        sync_in = 1'b0;
        step(2);
        chk(scan_start == 0, "R3 not yet", scan_start, 0);
        step(1);
        chk(scan_start == 1, "R3 start on falling edge", scan_start, 1);
        chk(wake == 0, "R9 no wake while awake", wake, 0);

        // R7 edges during running pass ignored
        sync_in = 1'b1; step(4);
        sync_in = 1'b0; step(6);
        chk(scan_start == 0, "R7 edge during pass", scan_start, 0);
        sync_in = 1'b1;

        // R5 + R8 timeout with clear in same cycle
        ms_tick = 1'b1;
        pulse_done();
        step(98);
        err_clr = 1'b1;
        step(1);
        chk(scan_start == 0, "R5 before timeout", scan_start, 0);
        step(1);
        err_clr = 1'b0;
        chk(scan_start == 1, "R5 timeout start", scan_start, 1);
        chk(sync_err == 1, "R8 set wins over clear", sync_err, 1);
        step(10);
        chk(sync_err == 1, "R8 sticky", sync_err, 1);
        err_clr = 1'b1; step(1); err_clr = 1'b0;
        step(1);
        chk(sync_err == 0, "R8 cleared", sync_err, 0);

        // R6 edge coincides with final tick
        pulse_done();
        step(97);
        sync_in = 1'b0;
        step(3);
        chk(scan_start == 1, "R6 start on tie", scan_start, 1);
        chk(sync_err == 0, "R6 edge wins no error", sync_err, 0);
        ms_tick = 1'b0;
        sync_in = 1'b1;
        step(4);

        // R11 disabling during wait
        pulse_done();
        step(3);
        chk(scan_start == 0, "R11 held", scan_start, 0);
        sync_en = 1'b0;
        step(1);
        chk(scan_start == 1, "R11 released", scan_start, 1);
        sync_en = 1'b1;
        step(2);

        // R9 wake during sleep
        pulse_done();
        sleep = 1'b1;
        sync_in = 1'b0;
        step(2);
        chk(wake == 0, "R9 wake latency", wake, 0);
        step(1);
        chk(wake == 1, "R9 wake pulse", wake, 1);
        chk(scan_start == 0, "R9 no start asleep", scan_start, 0);
        step(1);
        chk(wake == 0, "R9 wake one cycle", wake, 0);

        // R10 frozen timer during sleep
        ms_tick = 1'b1;
        step(150);
        chk(scan_start == 0 && sync_err == 0, "R10 no timeout asleep", sync_err, 0);
        sleep = 1'b0;
        step(120);
        chk(sync_err == 1, "R10 timeout after wake-up", sync_err, 1);
        ms_tick = 1'b0;
        step(5);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule